// File: doc/BRIEF.md
# Bit-Serial First-Order Wave Digital Allpass Section

This block is one first-order allpass stage for a lattice wave digital filter, built entirely from bit-serial arithmetic. Each stream's two's-complement samples arrive least-significant bit first. A one-cycle word-start pulse marks the first bit of every word. A symmetric two-port adaptor with a single fixed coefficient combines the new input with the stored state. The adaptor uses two serial adders, a serial-by-parallel shift-add multiplier and a recursive delay line. The section returns the allpass output on a matching serial line with its own word-start pulse.

The multiplier needs one cycle per data bit plus one per coefficient fraction bit, which is more than the recursive loop would otherwise allow. To meet the rate anyway, the section carries several independent streams on parallel lanes, with each lane's words skewed from its neighbour by one cycle. The recursive delay of every lane is sized so that the whole loop spans exactly one frame of data-width plus fraction-width cycles. A latched sign bit feeds the multiplier during the extra cycles. Every lane adds the same latency, so the output lanes keep the input skew and can feed the next cascaded section directly.

Top module: `wdf_allpass1_serial`

## Requirements
- R1: After reset, and before any word-start pulse, every `ser_out` and `word_start_out` bit is 0.
- R2: Lane k takes a DW-bit two's-complement word on `ser_in[k]`, LSB first, with bit 0 in the cycle where `word_start[k]` is 1. Its `word_start_out[k]` is 1 exactly FB+1 cycles later, in the cycle that carries output bit 0, and the output's DW bits follow LSB first.
- R3: `ser_out[k]` is 0 in every cycle outside the DW-cycle output window of a word.
- R4: With state s and input a, the section computes d = s - a (wrapped to DW bits) and p = floor(ALPHA*d / 2^FB). The output is s + p and the new state is a + p, both wrapped to DW bits.
- R5: The state of every lane is 0 after reset, so the first word is processed with s = 0.
- R6: Bits on `ser_in[k]` in frame cycles DW to DW+FB-1 after a word start have no effect on any output.
- R7: Consecutive word starts on a lane are at least DW+FB cycles apart. A longer gap leaves the stored state unchanged.
- R8: Lanes are independent. The output on one lane depends only on that lane's inputs, and each lane keeps its own input timing offset at its output.
- R9: Intermediate and final results wrap modulo 2^DW with no saturation, including for full-scale positive and negative words.
- R10: `word_start_out[k]` is a single-cycle pulse per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_start | input | LANES | Per-lane pulse marking input bit 0 |
| ser_in | input | LANES | Per-lane serial input data, LSB first |
| ser_out | output | LANES | Per-lane serial output data, LSB first |
| word_start_out | output | LANES | Per-lane pulse marking output bit 0 |

## Verification
The checker watches the framing on every cycle:
- the output pulse appears exactly FB+1 cycles after each input pulse, and never at any other time;
- the pulse is only one cycle wide;
- the output line stays low outside each word's window.

The arithmetic can only be shown by the bench's scenarios, which compare every output word with an integer model of the adaptor equations. Those scenarios cover:
- the impulse response recursion across words;
- random data with junk bits after the word;
- idle gaps between words;
- full-scale values that wrap.

// File: rtl/wdf_ap_pkg.sv
package wdf_ap_pkg;

  // Cycles in one word frame: data bits plus coefficient fraction bits.
  function automatic int frame_cycles(input int dw, input int fb);
    return dw + fb;
  endfunction

  // Counter width able to hold values 0..maxv.
  function automatic int ctr_bits(input int maxv);
    return $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/wdf_bs_add.sv
module wdf_bs_add #(
  parameter bit CIN0 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic a,
  input  logic b,
  output logic sum
);
  logic cy_q, cy_d, ci;

  always_comb begin
    ci   = first ? CIN0 : cy_q;
    sum  = a ^ b ^ ci;
    cy_d = (a & b) | (ci & (a ^ b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cy_q <= 1'b0;
    else        cy_q <= cy_d;
  end
endmodule

// File: rtl/wdf_sp_mult.sv
module wdf_sp_mult #(
  parameter int FB    = 4,
  parameter int ALPHA = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic x,
  output logic p
);
  localparam int AW = FB + 2;
  localparam logic signed [AW:0] COEF = (AW + 1)'(ALPHA);
  localparam logic signed [AW:0] NONE = '0;

  logic signed [AW-1:0] acc_q, acc_d, acc_eff;
  logic signed [AW:0]   s;

  always_comb begin
    acc_eff = first ? '0 : acc_q;
    s       = $signed({acc_eff[AW-1], acc_eff}) + (x ? COEF : NONE);
    p       = s[0];
    acc_d   = s[AW:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/wdf_ap1_lane.sv
module wdf_ap1_lane
  import wdf_ap_pkg::*;
#(
  parameter int DW    = 8,
  parameter int FB    = 4,
  parameter int ALPHA = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din,
  output logic dout,
  output logic dout_start
);
  localparam int P  = frame_cycles(DW, FB);
  localparam int PW = ctr_bits(P);
  localparam logic [PW-1:0] PH_IDLE = PW'(P);
  localparam logic [PW-1:0] PH_SGN  = PW'(DW - 1);
  localparam logic [PW-1:0] PH_DEND = PW'(DW);
  localparam logic [PW-1:0] PH_OUT0 = PW'(FB);
  localparam logic [PW-1:0] PH_OUTN = PW'(FB + DW - 1);

  logic [PW-1:0] cnt_q, phase;
  logic          active, first_in, first_out, win;
  logic [P-1:0]  sr_q, sr_d;
  logic [FB-1:0] a1d_q, a1d_d;
  logic          sgn_q, sgn_d;
  logic          dout_q, dout_d, dst_q, dst_d;
  logic          a2_now, a2_late, a1_late;
  logic          d_bit, x_bit, p_bit, b1_bit, b2_bit;

  // frame phase of the current cycle; idle value P when no word is running
  always_comb begin
    if (start)                phase = '0;
    else if (cnt_q == PH_IDLE) phase = PH_IDLE;
    else                      phase = cnt_q + 1'b1;
    active    = (phase != PH_IDLE);
    first_in  = (phase == '0);
    first_out = (phase == PH_OUT0);
    win       = (phase >= PH_OUT0) && (phase <= PH_OUTN);
  end

  // recursive delay: tap DW-1 feeds the subtractor, tap P-1 the output adder
  assign a2_now  = sr_q[DW-1];
  assign a2_late = sr_q[P-1];
  assign a1_late = a1d_q[FB-1];

  generate
    if (FB == 1) begin : g_a1_one
      assign a1d_d = din;
    end else begin : g_a1_chain
      assign a1d_d = {a1d_q[FB-2:0], din};
    end
  endgenerate

  wdf_bs_add #(.CIN0(1'b1)) u_sub (
    .clk(clk), .rst_n(rst_n), .first(first_in),
    .a(a2_now), .b(~din), .sum(d_bit)
  );

  // sign latch extends d while the multiplier runs past the data word
  always_comb begin
    x_bit = (phase < PH_DEND) ? d_bit : sgn_q;
    sgn_d = (phase == PH_SGN) ? d_bit : sgn_q;
  end

  wdf_sp_mult #(.FB(FB), .ALPHA(ALPHA)) u_mul (
    .clk(clk), .rst_n(rst_n), .first(first_in), .x(x_bit), .p(p_bit)
  );

  wdf_bs_add #(.CIN0(1'b0)) u_add_out (
    .clk(clk), .rst_n(rst_n), .first(first_out),
    .a(a2_late), .b(p_bit), .sum(b1_bit)
  );

  wdf_bs_add #(.CIN0(1'b0)) u_add_state (
    .clk(clk), .rst_n(rst_n), .first(first_out),
    .a(a1_late), .b(p_bit), .sum(b2_bit)
  );

  always_comb begin
    sr_d   = active ? {sr_q[P-2:0], b2_bit} : sr_q;
    dout_d = win & b1_bit;
    dst_d  = first_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= PH_IDLE;
      sr_q   <= '0;
      a1d_q  <= '0;
      sgn_q  <= 1'b0;
      dout_q <= 1'b0;
      dst_q  <= 1'b0;
    end else begin
      cnt_q  <= phase;
      sr_q   <= sr_d;
      a1d_q  <= a1d_d;
      sgn_q  <= sgn_d;
      dout_q <= dout_d;
      dst_q  <= dst_d;
    end
  end

  assign dout       = dout_q;
  assign dout_start = dst_q;
endmodule

// File: rtl/wdf_allpass1_serial.sv
module wdf_allpass1_serial #(
  parameter int DW    = 8,
  parameter int FB    = 4,
  parameter int ALPHA = 5,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] word_start,
  input  logic [LANES-1:0] ser_in,
  output logic [LANES-1:0] ser_out,
  output logic [LANES-1:0] word_start_out
);
  logic rs_q1, rs_q2;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      wdf_ap1_lane #(.DW(DW), .FB(FB), .ALPHA(ALPHA)) u_lane (
        .clk(clk), .rst_n(rs_q2),
        .start(word_start[k]), .din(ser_in[k]),
        .dout(ser_out[k]), .dout_start(word_start_out[k])
      );
    end
  endgenerate
endmodule

// File: rtl/wdf_allpass1_chk.sv
module wdf_allpass1_chk
  import wdf_ap_pkg::*;
#(
  parameter int DW    = 8,
  parameter int FB    = 4,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] word_start,
  input logic [LANES-1:0] ser_out,
  input logic [LANES-1:0] word_start_out
);
  localparam int P   = frame_cycles(DW, FB);
  localparam int SAT = P + 1;
  localparam int CW  = ctr_bits(SAT);
  localparam logic [CW-1:0] C_SAT = CW'(SAT);
  localparam logic [CW-1:0] C_LAT = CW'(FB + 1);
  localparam logic [CW-1:0] C_END = CW'(FB + DW);

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_chk
      logic [CW-1:0] age_q;

      // cycles since the last input word start on this lane, saturating
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               age_q <= C_SAT;
        else if (word_start[k])   age_q <= CW'(1);
        else if (age_q != C_SAT)  age_q <= age_q + 1'b1;
      end

      a_r2_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_out[k] |-> (age_q == C_LAT));

      a_r2_strobe_present: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == C_LAT) |-> word_start_out[k]);

      a_r3_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !((age_q >= C_LAT) && (age_q <= C_END)) |-> !ser_out[k]);

      a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_out[k] |=> !word_start_out[k]);
    end
  endgenerate
endmodule

bind wdf_allpass1_serial wdf_allpass1_chk #(.DW(DW), .FB(FB), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_start(word_start),
  .ser_out(ser_out), .word_start_out(word_start_out)
);

// File: tb/sim_wdf_allpass1_serial.sv
`timescale 1ns/1ps
module sim_wdf_allpass1_serial;
  localparam int DW = 8;
  localparam int FB = 4;
  localparam int AL = 5;
  localparam int NL = 4;
  localparam int P  = DW + FB;
  localparam int NF = 16;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] word_start;
  logic [NL-1:0] ser_in;
  logic [NL-1:0] ser_out;
  logic [NL-1:0] word_start_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] wq  [NL][NF];
  logic [DW-1:0] got [NL][NF];
  logic [DW-1:0] st  [NL];

  wdf_allpass1_serial #(.DW(DW), .FB(FB), .ALPHA(AL), .LANES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .ser_in(ser_in),
    .ser_out(ser_out), .word_start_out(word_start_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // integer model of one adaptor step for lane k
  task automatic model_step(input int k, input logic [DW-1:0] a1, output logic [DW-1:0] b1);
    logic signed [DW-1:0] d;
    int prod, p;
    d    = st[k] - a1;
    prod = AL * int'(d);
    p    = prod >>> FB;
    b1   = st[k] + p[DW-1:0];
    st[k] = a1 + p[DW-1:0];
  endtask

  // drive nfr words per lane (lane k offset by k cycles) and check everything
  task automatic run_block(input string tag, input int nfr, input int gap, input bit junk);
    int span, ws_err, quiet_err;
    logic [DW-1:0] exp;
    span = P + gap;
    ws_err = 0;
    quiet_err = 0;
    for (int g = 0; g < nfr * span + NL + 3; g++) begin
      @(negedge clk);
      for (int k = 0; k < NL; k++) begin
        int rel, f, ph;
        bit exp_ws, inwin;
        rel = g - 1 - k;
        exp_ws = 0;
        inwin = 0;
        f = 0;
        ph = 0;
        if (rel >= 0 && rel / span < nfr) begin
          f  = rel / span;
          ph = rel % span;
          exp_ws = (ph == FB);
          inwin  = (ph >= FB) && (ph < FB + DW);
        end
        if (word_start_out[k] !== exp_ws) ws_err++;
        if (inwin) got[k][f][ph-FB] = ser_out[k];
        else if (ser_out[k] !== 1'b0) quiet_err++;
      end
      for (int k = 0; k < NL; k++) begin
        int rel, f, ph;
        rel = g - k;
        if (rel >= 0 && rel / span < nfr) begin
          f  = rel / span;
          ph = rel % span;
          word_start[k] = (ph == 0);
          if (ph < DW)      ser_in[k] = wq[k][f][ph];
          else if (junk)    ser_in[k] = 1'($urandom);
          else              ser_in[k] = 1'b0;
        end else begin
          word_start[k] = 1'b0;
          ser_in[k]     = 1'b0;
        end
      end
    end
    check({tag, " R2 R10 strobe timing"}, 32'(ws_err), 32'd0);
    check({tag, " R3 quiet outside window"}, 32'(quiet_err), 32'd0);
    for (int f = 0; f < nfr; f++)
      for (int k = 0; k < NL; k++) begin
        model_step(k, wq[k][f], exp);
        check($sformatf("%s R4 R8 lane%0d word%0d", tag, k, f), 32'(got[k][f]), 32'(exp));
      end
  endtask

  task automatic t_reset;
    int errs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ser_out !== '0 || word_start_out !== '0) errs++;
    end
    check("R1 idle after reset", 32'(errs), 32'd0);
  endtask

  task automatic t_impulse;
    for (int k = 0; k < NL; k++)
      for (int f = 0; f < NF; f++) wq[k][f] = '0;
    wq[0][0] = 8'h40;
    wq[1][0] = 8'hC0;
    wq[2][0] = 8'h7F;
    wq[3][0] = 8'h01;
    run_block("R5 impulse", 8, 0, 1'b0);
  endtask

  task automatic t_random;
    for (int k = 0; k < NL; k++)
      for (int f = 0; f < NF; f++) wq[k][f] = DW'($urandom);
    run_block("R6 random with junk", 12, 0, 1'b1);
  endtask

  task automatic t_gap;
    for (int k = 0; k < NL; k++)
      for (int f = 0; f < NF; f++) wq[k][f] = DW'($urandom);
    run_block("R7 gaps", 6, 5, 1'b1);
  endtask

  task automatic t_extreme;
    for (int k = 0; k < NL; k++)
      for (int f = 0; f < NF; f++)
        case ((f + k) % 4)
          0: wq[k][f] = 8'h80;
          1: wq[k][f] = 8'h7F;
          2: wq[k][f] = 8'hFF;
          default: wq[k][f] = 8'h80;
        endcase
    run_block("R9 extremes", 10, 0, 1'b0);
  endtask

  initial begin
    for (int k = 0; k < NL; k++) st[k] = '0;
    rst_n = 1'b0;
    word_start = '0;
    ser_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_impulse();
    t_random();
    repeat (7) @(negedge clk);
    t_gap();
    t_extreme();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule